// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the sequence of column addresses for one read or write burst, starting from the column given with the command. Data moves on both clock edges, so each clock it presents a pair of addresses: the even-numbered beat and the odd-numbered beat that follows it. The burst length (2, 4, 8 or a whole page) and the ordering (sequential or interleaved) are sampled with each start command. They normally come from the mode register.

A start command that arrives while a burst is running acts as an interrupting read. The remaining addresses of the old burst are dropped, and a new burst of the full programmed length begins from the new column. A stop input covers both burst stop and precharge, and it ends the burst. A whole-page burst always runs sequentially and wraps from the top column back to column zero. It never ends by itself. A whole-page burst is only legal from an even column: an odd start column is forced even and flagged.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, valid, last and err are all 0.
- R2: Burst length select encoding is 0 = 2, 1 = 4, 2 = 8, 3 = whole page. The ordering select is 0 = sequential, 1 = interleaved. The first address pair appears in the cycle after the start is sampled. For lengths 2, 4 and 8, col_even of that first pair equals the start column.
- R3: Each valid cycle carries beat k on col_even and beat k+1 on col_odd, with k even. A burst of length 2, 4 or 8 stays valid for exactly length/2 cycles. last is high only in its final cycle, and valid drops in the next cycle unless a new start is sampled.
- R4: In sequential order, beat k is at column (start with its low log2(length) bits cleared) + ((start + k) mod length), so the burst wraps inside its aligned block.
- R5: In interleaved order, beat k is at column start XOR k.
- R6: A whole-page burst is sequential even when interleaved order is selected. It steps through all 256 columns, wraps from column 255 to column 0, and never raises last.
- R7: A whole-page start with an odd column clears bit 0 of the start column and sets err. err keeps the value decided at the most recent start.
- R8: A start sampled while a burst is valid discards the remaining beats. It restarts at beat 0 from the new column with the newly sampled full length and order.
- R9: A stop sampled without a start makes valid low in the next cycle. If start and stop are sampled together, the start wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Read/write command; interrupts a running burst |
| start_col | input | COL_W | Starting column of the burst |
| blen_sel | input | 2 | Burst length select |
| ilv_sel | input | 1 | 1 = interleaved order |
| stop | input | 1 | Burst stop or precharge |
| col_even | output | COL_W | Column of the even beat this cycle |
| col_odd | output | COL_W | Column of the odd beat this cycle |
| valid | output | 1 | Address pair is valid |
| last | output | 1 | Final pair of a fixed-length burst |
| err | output | 1 | Whole-page burst started from an odd column |

## Verification
A wrong beat counter shows up as a wrong column in the same cycle it occurs, or as last arriving a cycle early or late; the bench compares every pair on every cycle. A wrong block base or wrap mask appears as soon as a burst crosses its block boundary, so the starting columns are chosen to wrap on the second beat. A lost page flag or a lost restart shows up within one cycle: last appears in the middle of a page, or the old sequence continues after a start.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
    typedef enum logic [1:0] {
        BLEN_2    = 2'd0,
        BLEN_4    = 2'd1,
        BLEN_8    = 2'd2,
        BLEN_PAGE = 2'd3
    } blen_e;
endpackage

// File: rtl/bcg_addr_calc.sv
module bcg_addr_calc #(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] beat,
    input  logic [COL_W-1:0] mask,
    input  logic             ilv,
    output logic [COL_W-1:0] addr
);
    logic [COL_W-1:0] seq_addr;
    logic [COL_W-1:0] ilv_addr;

    always_comb begin
        seq_addr = (base & ~mask) | ((base + beat) & mask);
        ilv_addr = base ^ beat;
        addr     = ilv ? ilv_addr : seq_addr;
    end
endmodule

// File: rtl/bcg_ctrl.sv
module bcg_ctrl
    import bcg_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  logic [1:0]       blen_sel,
    input  logic             ilv_sel,
    input  logic             stop,
    output logic [COL_W-1:0] base,
    output logic [COL_W-1:0] mask,
    output logic [COL_W-1:0] beat,
    output logic             ilv,
    output logic             active,
    output logic             fin,
    output logic             err
);
    typedef struct packed {
        logic             active;
        logic             page;
        logic             ilv;
        logic             err;
        logic [COL_W-1:0] base;
        logic [COL_W-1:0] mask;
        logic [COL_W-1:0] beat;
    } st_t;

    st_t   st_d, st_q;
    blen_e bl_w;
    logic  page_w;
    logic  fin_w;

    always_comb begin
        st_d   = st_q;
        bl_w   = blen_e'(blen_sel);
        page_w = (bl_w == BLEN_PAGE);
        fin_w  = st_q.active && !st_q.page &&
                 ((st_q.beat | COL_W'(1)) == st_q.mask);
        if (start) begin
            st_d.active = 1'b1;
            st_d.page   = page_w;
            st_d.base   = page_w ? {start_col[COL_W-1:1], 1'b0} : start_col;
            st_d.mask   = page_w ? '1 : ((COL_W'(2) << blen_sel) - COL_W'(1));
            st_d.ilv    = ilv_sel && !page_w;
            st_d.err    = page_w && start_col[0];
            st_d.beat   = '0;
        end else if (stop) begin
            st_d.active = 1'b0;
            st_d.beat   = '0;
        end else if (st_q.active) begin
            if (fin_w) begin
                st_d.active = 1'b0;
            end
            st_d.beat = st_q.beat + COL_W'(2);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign base   = st_q.base;
    assign mask   = st_q.mask;
    assign beat   = st_q.beat;
    assign ilv    = st_q.ilv;
    assign active = st_q.active;
    assign fin    = fin_w;
    assign err    = st_q.err;
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen #(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  logic [1:0]       blen_sel,
    input  logic             ilv_sel,
    input  logic             stop,
    output logic [COL_W-1:0] col_even,
    output logic [COL_W-1:0] col_odd,
    output logic             valid,
    output logic             last,
    output logic             err
);
    logic [COL_W-1:0] base_w, mask_w, beat_w;
    logic             ilv_w;
    logic [COL_W-1:0] pair_w [2];

    bcg_ctrl #(.COL_W(COL_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .start_col (start_col),
        .blen_sel  (blen_sel),
        .ilv_sel   (ilv_sel),
        .stop      (stop),
        .base      (base_w),
        .mask      (mask_w),
        .beat      (beat_w),
        .ilv       (ilv_w),
        .active    (valid),
        .fin       (last),
        .err       (err)
    );

    for (genvar g = 0; g < 2; g++) begin : g_lane
        bcg_addr_calc #(.COL_W(COL_W)) u_calc (
            .base (base_w),
            .beat (beat_w | COL_W'(g)),
            .mask (mask_w),
            .ilv  (ilv_w),
            .addr (pair_w[g])
        );
    end

    assign col_even = pair_w[0];
    assign col_odd  = pair_w[1];
endmodule

// File: rtl/bcg_checker.sv
module bcg_checker #(
    parameter int COL_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [COL_W-1:0] start_col,
    input logic [1:0]       blen_sel,
    input logic             stop,
    input logic [COL_W-1:0] col_even,
    input logic             valid,
    input logic             last,
    input logic             err
);
    a_r2_first_col: assert property (@(posedge clk) disable iff (!rst_n)
        start && blen_sel != 2'd3 |=> valid && col_even == $past(start_col));

    a_r7_page_even: assert property (@(posedge clk) disable iff (!rst_n)
        start && blen_sel == 2'd3 |=>
            col_even == ($past(start_col) & ~COL_W'(1)) && err == $past(start_col[0]));

    a_r6_page_no_last: assert property (@(posedge clk) disable iff (!rst_n)
        start && blen_sel == 2'd3 |=> !last);

    a_r3_last_valid: assert property (@(posedge clk) disable iff (!rst_n)
        last |-> valid);

    a_r3_end_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        valid && last && !start |=> !valid);

    a_r9_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        stop && !start |=> !valid);
endmodule

bind burst_col_gen bcg_checker #(.COL_W(COL_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .start_col (start_col),
    .blen_sel  (blen_sel),
    .stop      (stop),
    .col_even  (col_even),
    .valid     (valid),
    .last      (last),
    .err       (err)
);

// File: tb/burst_col_gen_bench.sv
`timescale 1ns/1ps
module burst_col_gen_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] start_col = '0;
    logic [1:0] blen_sel = '0;
    logic       ilv_sel = 1'b0;
    logic       stop = 1'b0;
    logic [7:0] col_even, col_odd;
    logic       valid, last, err;

    int total = 0;
    int bad = 0;
    bit done = 0;

    int m_active = 0, m_page = 0, m_ilv = 0, m_err = 0;
    int m_base = 0, m_bl = 2, m_k = 0;

    always #10 clk = ~clk;

    burst_col_gen u_burst_col_gen (
        .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
        .blen_sel(blen_sel), .ilv_sel(ilv_sel), .stop(stop),
        .col_even(col_even), .col_odd(col_odd), .valid(valid),
        .last(last), .err(err)
    );

    function automatic int exp_col(int base, int k, int bl, int il);
        if (il != 0) return (base ^ k) & 255;
        return ((base & ~(bl - 1)) | ((base + k) & (bl - 1))) & 255;
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic step(string tag, bit go, int col, int bl, bit il, bit stp);
        start = go; start_col = col[7:0]; blen_sel = bl[1:0]; ilv_sel = il; stop = stp;
        @(posedge clk);
        if (go) begin
            m_active = 1;
            m_page = (bl == 3) ? 1 : 0;
            m_bl = m_page ? 256 : (2 << bl);
            m_base = m_page ? (col & 254) : col;
            m_ilv = (il && !m_page) ? 1 : 0;
            m_err = (m_page && (col & 1)) ? 1 : 0;
            m_k = 0;
        end else if (stp) begin
            m_active = 0;
        end else if (m_active != 0) begin
            if (!m_page && m_k + 2 == m_bl) m_active = 0;
            m_k = (m_k + 2) % 256;
        end
        @(negedge clk);
        start = 1'b0; stop = 1'b0;
        chk(tag, "valid", valid, m_active);
        chk(tag, "err", err, m_err);
        if (m_active != 0) begin
            chk(tag, "col_even", col_even, exp_col(m_base, m_k, m_bl, m_ilv));
            chk(tag, "col_odd", col_odd, exp_col(m_base, m_k + 1, m_bl, m_ilv));
            chk(tag, "last", last, (!m_page && m_k + 2 == m_bl) ? 1 : 0);
        end else begin
            chk(tag, "last", last, 0);
        end
    endtask

    task automatic idle(string tag, int n);
        for (int i = 0; i < n; i++) step(tag, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "valid", valid, 0);
        chk("R1", "last", last, 0);
        chk("R1", "err", err, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R2 R3 R4 length 2, odd start wraps within pair
        step("R2", 1, 5, 0, 0, 0);
        idle("R3", 2);
        // R4 length 4 sequential crossing the block end
        step("R4", 1, 6, 1, 0, 0);
        idle("R4", 3);
        // R4 length 8 sequential
        step("R4", 1, 8'h2d, 2, 0, 0);
        idle("R4", 5);
        // R5 interleaved lengths 8 and 4
        step("R5", 1, 3, 2, 1, 0);
        idle("R5", 4);
        step("R5", 1, 8'h96, 1, 1, 0);
        idle("R5", 2);
        // R6 whole page wrap at 255, interleave request ignored
        step("R6", 1, 252, 3, 1, 0);
        idle("R6", 6);
        step("R9", 0, 0, 0, 0, 1);
        idle("R9", 1);
        // R7 odd whole-page start
        step("R7", 1, 9, 3, 0, 0);
        idle("R7", 2);
        step("R9", 0, 0, 0, 0, 1);
        step("R7", 1, 4, 0, 0, 0);
        // R8 interrupt mid length-8 burst
        step("R8", 1, 16, 2, 0, 0);
        idle("R8", 1);
        step("R8", 1, 41, 2, 1, 0);
        idle("R8", 5);
        // R9 stop mid burst, then start and stop together
        step("R9", 1, 64, 2, 0, 0);
        step("R9", 0, 0, 0, 0, 1);
        idle("R9", 1);
        step("R9", 1, 70, 1, 0, 1);
        idle("R9", 3);
        // random mix
        begin
            int seed = 0;
            void'($urandom(32'h5eed1234));
            seed = 1;
            for (int i = 0; i < 400; i++) begin
                bit go = ($urandom % 4) == 0;
                bit sp = ($urandom % 8) == 0;
                step("R3", go, $urandom % 256, $urandom % 4, $urandom % 2, sp);
            end
            if (seed != 1) chk("R3", "seed", seed, 1);
        end
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule